// File: doc/BRIEF.md
# Set-Associative Cache Access Pipeline

This block is the array-access path of a set-associative cache. A lookup carries a set index, an address tag and a caller-chosen identifier. Stage one starts the tag array read. Stage two compares the stored tags of every way against the request and starts the data array read. Stage three presents the result at the exit: hit flag, hit way, coherence state, the stored line and a replacement candidate. Each tag entry holds a tag and a two-bit coherence state. Both arrays are modelled inside the block as synchronous RAMs with one cycle of read latency.

The exit stage is also the only write port. While a result is at the exit, the caller may write a new tag and state into one way of that result's set, and optionally a new line. The block forwards such a write to the two younger lookups still in flight. Every lookup therefore sees the array contents left by all older lookups, exactly as if the lookups had run one at a time. The replacement candidate comes from a per-set round-robin pointer. A single stall input freezes the whole pipe. Miss handling and coherence messaging are left to the caller.

Top module: `cache_access_pipe`

## Requirements
- R1: After reset no result is presented (`out_valid` low), every tag entry is Invalid and every set's replacement pointer is way 0, so the first lookup of any set misses with `out_victim` = 0.
- R2: A lookup presented with `req_valid` high in a cycle with `stall` low appears at the exit after exactly two non-stalled clock edges. Lookups leave in issue order and carry their own `out_id`, `out_index` and `out_tag`.
- R3: State encoding is 0 = Invalid, 1 = Shared, 2 = Exclusive, 3 = Modified. A lookup hits only if some way of its set holds an equal tag with a state other than 0. On a hit, `out_way` is that way and `out_state` is its state. Writing state 0 into a way makes later lookups of that tag miss.
- R4: A write is applied at the clock edge that ends a cycle in which `upd_en`, `out_valid` are high and `stall` is low. It stores `upd_tag`/`upd_state` into way `upd_way` of set `out_index`.
- R5: On a hit, `out_line` is the line most recently written into the hit way.
- R6: A lookup issued one cycle after another lookup of the same set sees the write made for the older lookup, both in hit/way/state and in line.
- R7: A lookup issued two cycles after a lookup of the same set sees the write made for that older lookup, both in its tag match and in its line.
- R8: On a miss, `out_victim` gives the set's round-robin pointer. The pointer advances by one, wrapping from the last way to way 0, each time a write is applied for a lookup that missed. Pointers of other sets do not change.
- R9: While `stall` is high, no lookup is accepted, the exit result is held unchanged, and any write requested at the exit is not applied.
- R10: A write with `upd_line_we` low changes tag and state only. The way's line is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes every stage and blocks writes |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_id | input | ID_W | Caller identifier carried with the lookup |
| req_index | input | IDX_W | Set index |
| req_tag | input | TAG_W | Address tag to compare |
| out_valid | output | 1 | A result is at the exit |
| out_id | output | ID_W | Identifier of the exit result |
| out_index | output | IDX_W | Set index of the exit result |
| out_tag | output | TAG_W | Tag of the exit result |
| out_hit | output | 1 | Exit result hit |
| out_way | output | WAY_W | Hit way |
| out_state | output | 2 | Coherence state of the hit way |
| out_line | output | LINE_W | Line held by the hit way |
| out_victim | output | WAY_W | Round-robin replacement candidate of the set |
| upd_en | input | 1 | Write tag and state for the exit result |
| upd_way | input | WAY_W | Way to write |
| upd_tag | input | TAG_W | New tag |
| upd_state | input | 2 | New coherence state |
| upd_line_we | input | 1 | Also write the line |
| upd_line | input | LINE_W | New line |

## Verification
A stale forwarding path would show up at the exit one or two cycles after a write to the same set. The younger lookup would report a miss, or the wrong way or state, or an old line. Back-to-back lookups of one set are therefore checked against a model that applies writes in program order. A corrupted replacement pointer appears on the very next miss of that set. A write that leaks through a stall corrupts an entry and is caught the next time that tag is looked up. A lost or duplicated lookup breaks the order of identifiers at once.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } coh_state_e;
endpackage

// File: rtl/cap_tag_ram.sv
// Tag/state array: synchronous read of all ways of one set, one-way write.
// Read returns the contents before a same-edge write.
module cap_tag_ram #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [1:0]                   wr_state,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][1:0]         rd_state
);
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [1:0]       st_mem  [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          st_mem[s][w] <= 2'd0;
    end else if (wr_en) begin
      st_mem[wr_idx][wr_way] <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        rd_tag[w]   <= tag_mem[rd_idx][w];
        rd_state[w] <= st_mem[rd_idx][w];
      end
    end
  end
endmodule

// File: rtl/cap_data_ram.sv
// Line array: synchronous read of all ways of one set, one-way write.
module cap_data_ram #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [LINE_W-1:0]           wr_line,
  output logic [WAYS-1:0][LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] line_mem [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx][wr_way] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int w = 0; w < WAYS; w++) rd_line[w] <= line_mem[rd_idx][w];
    end
  end
endmodule

// File: rtl/cap_way_match.sv
// Tag comparison across ways with two forwarding sources:
// a write captured at the edge of the tag read (older) and the write
// happening in the current cycle (newer, takes precedence).
module cap_way_match
  import cap_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]           cmp_tag,
  input  logic [WAYS-1:0][TAG_W-1:0] ram_tag,
  input  logic [WAYS-1:0][1:0]       ram_state,
  input  logic                       old_en,
  input  logic [WAY_W-1:0]           old_way,
  input  logic [TAG_W-1:0]           old_tag,
  input  logic [1:0]                 old_state,
  input  logic                       new_en,
  input  logic [WAY_W-1:0]           new_way,
  input  logic [TAG_W-1:0]           new_tag,
  input  logic [1:0]                 new_state,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [1:0]                 hit_state
);
  logic [WAYS-1:0][TAG_W-1:0] eff_tag;
  logic [WAYS-1:0][1:0]       eff_state;
  logic [WAYS-1:0]            match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic use_new, use_old;
    assign use_new      = new_en && (new_way == WAY_W'(w));
    assign use_old      = old_en && (old_way == WAY_W'(w));
    assign eff_tag[w]   = use_new ? new_tag   : use_old ? old_tag   : ram_tag[w];
    assign eff_state[w] = use_new ? new_state : use_old ? old_state : ram_state[w];
    assign match[w]     = (eff_state[w] != ST_I) && (eff_tag[w] == cmp_tag);
  end

  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    hit_state = ST_I;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit       = 1'b1;
        hit_way   = WAY_W'(w);
        hit_state = eff_state[w];
      end
    end
  end
endmodule

// File: rtl/cache_access_pipe.sv
// Three-stage lookup: S1 issues tag read, S2 matches and issues data read,
// S3 presents the result and accepts the write for it.
module cache_access_pipe
  import cap_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 64,
  parameter int ID_W   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [IDX_W-1:0]  out_index,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_hit,
  output logic [WAY_W-1:0]  out_way,
  output logic [1:0]        out_state,
  output logic [LINE_W-1:0] out_line,
  output logic [WAY_W-1:0]  out_victim,
  input  logic              upd_en,
  input  logic [WAY_W-1:0]  upd_way,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [1:0]        upd_state,
  input  logic              upd_line_we,
  input  logic [LINE_W-1:0] upd_line
);
  // ---------------- control ----------------
  logic advance, upd_fire;

  // stage 2 registers
  logic              s2_valid_q;
  logic [ID_W-1:0]   s2_id_q;
  logic [IDX_W-1:0]  s2_idx_q;
  logic [TAG_W-1:0]  s2_tag_q;
  logic              s2_fw_en_q;
  logic [WAY_W-1:0]  s2_fw_way_q;
  logic [TAG_W-1:0]  s2_fw_tag_q;
  logic [1:0]        s2_fw_st_q;
  logic              s2_fw_en_d;

  // stage 3 registers
  logic              s3_valid_q;
  logic [ID_W-1:0]   s3_id_q;
  logic [IDX_W-1:0]  s3_idx_q;
  logic [TAG_W-1:0]  s3_tag_q;
  logic              s3_hit_q;
  logic [WAY_W-1:0]  s3_way_q;
  logic [1:0]        s3_st_q;
  logic              s3_dfw_en_q;
  logic [WAY_W-1:0]  s3_dfw_way_q;
  logic [LINE_W-1:0] s3_dfw_line_q;
  logic              s3_dfw_en_d;

  // array outputs and match results
  logic [WAYS-1:0][TAG_W-1:0]  ram_tag;
  logic [WAYS-1:0][1:0]        ram_state;
  logic [WAYS-1:0][LINE_W-1:0] ram_line;
  logic                        live_fw;
  logic                        m_hit;
  logic [WAY_W-1:0]            m_way;
  logic [1:0]                  m_state;

  // replacement pointers
  logic [WAY_W-1:0] rr_q [SETS];
  logic             rr_step;
  logic [WAY_W-1:0] rr_next;

  assign advance  = ~stall;
  assign upd_fire = upd_en & s3_valid_q & advance;

  // ---------------- arrays ----------------
  cap_tag_ram #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (advance),
    .rd_idx   (req_index),
    .wr_en    (upd_fire),
    .wr_idx   (s3_idx_q),
    .wr_way   (upd_way),
    .wr_tag   (upd_tag),
    .wr_state (upd_state),
    .rd_tag   (ram_tag),
    .rd_state (ram_state)
  );

  cap_data_ram #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_en   (advance),
    .rd_idx  (s2_idx_q),
    .wr_en   (upd_fire & upd_line_we),
    .wr_idx  (s3_idx_q),
    .wr_way  (upd_way),
    .wr_line (upd_line),
    .rd_line (ram_line)
  );

  // ---------------- stage 2: match with forwarding ----------------
  assign live_fw = upd_fire & (s3_idx_q == s2_idx_q);

  cap_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .cmp_tag   (s2_tag_q),
    .ram_tag   (ram_tag),
    .ram_state (ram_state),
    .old_en    (s2_fw_en_q),
    .old_way   (s2_fw_way_q),
    .old_tag   (s2_fw_tag_q),
    .old_state (s2_fw_st_q),
    .new_en    (live_fw),
    .new_way   (upd_way),
    .new_tag   (upd_tag),
    .new_state (upd_state),
    .hit       (m_hit),
    .hit_way   (m_way),
    .hit_state (m_state)
  );

  // ---------------- next-state ----------------
  always_comb begin
    s2_fw_en_d  = upd_fire & (s3_idx_q == req_index);
    s3_dfw_en_d = live_fw & upd_line_we;
    rr_step     = upd_fire & ~s3_hit_q;
    rr_next     = rr_q[s3_idx_q] + WAY_W'(1);
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q  <= 1'b0;
      s2_fw_en_q  <= 1'b0;
      s3_valid_q  <= 1'b0;
      s3_dfw_en_q <= 1'b0;
    end else if (advance) begin
      s2_valid_q  <= req_valid;
      s2_fw_en_q  <= s2_fw_en_d;
      s3_valid_q  <= s2_valid_q;
      s3_dfw_en_q <= s3_dfw_en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      s2_id_q       <= req_id;
      s2_idx_q      <= req_index;
      s2_tag_q      <= req_tag;
      s2_fw_way_q   <= upd_way;
      s2_fw_tag_q   <= upd_tag;
      s2_fw_st_q    <= upd_state;
      s3_id_q       <= s2_id_q;
      s3_idx_q      <= s2_idx_q;
      s3_tag_q      <= s2_tag_q;
      s3_hit_q      <= m_hit;
      s3_way_q      <= m_way;
      s3_st_q       <= m_state;
      s3_dfw_way_q  <= upd_way;
      s3_dfw_line_q <= upd_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (rr_step) begin
      rr_q[s3_idx_q] <= rr_next;
    end
  end

  // ---------------- exit ----------------
  assign out_valid  = s3_valid_q;
  assign out_id     = s3_id_q;
  assign out_index  = s3_idx_q;
  assign out_tag    = s3_tag_q;
  assign out_hit    = s3_hit_q;
  assign out_way    = s3_way_q;
  assign out_state  = s3_st_q;
  assign out_victim = rr_q[s3_idx_q];
  assign out_line   = (s3_dfw_en_q && (s3_dfw_way_q == s3_way_q)) ? s3_dfw_line_q
                                                                  : ram_line[s3_way_q];

  // ---------------- assertions ----------------
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && out_valid) |=> (out_valid && $stable(out_id) && $stable(out_index)));

  assert_upd_at_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> out_valid);

  assert_hit_not_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_state != ST_I));

  assert_victim_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && out_valid && !stall && !out_hit) |=>
      (rr_q[$past(s3_idx_q)] == WAY_W'($past(out_victim) + WAY_W'(1))));
endmodule

// File: tb/tb_cache_access_pipe.sv
module tb_cache_access_pipe;
  localparam int SETS = 16, WAYS = 4, TAG_W = 8, LINE_W = 64, ID_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic req_valid = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic [3:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic out_valid, out_hit;
  logic [ID_W-1:0] out_id;
  logic [3:0] out_index;
  logic [TAG_W-1:0] out_tag;
  logic [1:0] out_way, out_victim, out_state;
  logic [LINE_W-1:0] out_line;
  logic upd_en = 1'b0;
  logic [1:0] upd_way = '0;
  logic [TAG_W-1:0] upd_tag = '0;
  logic [1:0] upd_state = '0;
  logic upd_line_we = 1'b0;
  logic [LINE_W-1:0] upd_line = '0;

  always #5 clk = ~clk;

  cache_access_pipe #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .req_valid(req_valid), .req_id(req_id),
    .req_index(req_index), .req_tag(req_tag), .out_valid(out_valid), .out_id(out_id),
    .out_index(out_index), .out_tag(out_tag), .out_hit(out_hit), .out_way(out_way),
    .out_state(out_state), .out_line(out_line), .out_victim(out_victim), .upd_en(upd_en),
    .upd_way(upd_way), .upd_tag(upd_tag), .upd_state(upd_state), .upd_line_we(upd_line_we),
    .upd_line(upd_line));

  typedef struct {
    int          id;
    int          idx;
    int          tag;
    bit          upd;
    int          wmode;   // 0 fixed way, 1 victim, 2 hit way else victim
    int          wway;
    int          ntag;
    int          nst;
    bit          we;
    logic [63:0] line;
    string       lbl;
    int          t0;
  } item_t;

  item_t q[$];
  int n_tests = 0, n_fail = 0;
  int adv_cnt = 0;
  int next_id = 0;
  bit done = 0;

  int          m_tag [SETS][WAYS];
  int          m_st  [SETS][WAYS];
  logic [63:0] m_line[SETS][WAYS];
  bit          m_lk  [SETS][WAYS];
  int          m_rr  [SETS];

  always @(posedge clk) if (rst_n && !stall) adv_cnt <= adv_cnt + 1;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // driver: one call per cycle, starting at a falling edge
  task automatic cyc(input bit st, input bit v, input item_t it);
    stall     = st;
    req_valid = v;
    req_id    = ID_W'(it.id);
    req_index = 4'(it.idx);
    req_tag   = TAG_W'(it.tag);
    if (v && !st) begin
      it.t0 = adv_cnt;
      q.push_back(it);
    end
    @(negedge clk);
  endtask

  task automatic lookup(input int idx, input int tag, input bit upd, input int wmode,
                        input int nst, input bit we, input logic [63:0] line, input string lbl);
    item_t it;
    it.id = next_id; next_id = (next_id + 1) % 16;
    it.idx = idx; it.tag = tag; it.upd = upd; it.wmode = wmode; it.wway = 0;
    it.ntag = tag; it.nst = nst; it.we = we; it.line = line; it.lbl = lbl; it.t0 = 0;
    cyc(1'b0, 1'b1, it);
  endtask

  task automatic idle(input int n);
    item_t it;
    it.id = 0; it.idx = 0; it.tag = 0; it.upd = 0; it.wmode = 0; it.wway = 0;
    it.ntag = 0; it.nst = 0; it.we = 0; it.line = '0; it.lbl = ""; it.t0 = 0;
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, it);
  endtask

  task automatic stall_cycles(input int n);
    item_t it;
    it.id = 9; it.idx = 5; it.tag = 8'h66; it.upd = 0; it.wmode = 0; it.wway = 0;
    it.ntag = 0; it.nst = 0; it.we = 0; it.line = '0; it.lbl = "R9"; it.t0 = 0;
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, it);
  endtask

  // monitor / scoreboard
  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_tag[s][w] = 0; m_st[s][w] = 0; m_line[s][w] = '0; m_lk[s][w] = 0;
      end
    end
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      upd_en = 1'b0;
      if (out_valid && stall) begin
        if (q.size() > 0) chk(out_id == ID_W'(q[0].id), "R9 held id", out_id, q[0].id);
        upd_en = 1'b1; upd_way = 2'd0; upd_tag = 8'hEE; upd_state = 2'd3;
        upd_line_we = 1'b1; upd_line = '1;
      end else if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", out_id, 0);
        end else begin
          item_t it;
          int hw;
          bit eh;
          int way;
          it = q.pop_front();
          chk(adv_cnt - it.t0 == 2, "R2 latency", adv_cnt - it.t0, 2);
          chk(out_id == ID_W'(it.id) && out_index == 4'(it.idx) && out_tag == TAG_W'(it.tag),
              "R2 order/fields", {out_id, out_index, out_tag}, {4'(it.id), 4'(it.idx), 8'(it.tag)});
          eh = 0; hw = 0;
          for (int w = WAYS - 1; w >= 0; w--)
            if (m_st[it.idx][w] != 0 && m_tag[it.idx][w] == it.tag) begin eh = 1; hw = w; end
          chk(out_hit == eh, {"R3 hit ", it.lbl}, out_hit, eh);
          if (eh) begin
            chk(out_way == 2'(hw) && out_state == 2'(m_st[it.idx][hw]), {"R3 way/state ", it.lbl},
                {out_way, out_state}, {2'(hw), 2'(m_st[it.idx][hw])});
            if (m_lk[it.idx][hw])
              chk(out_line == m_line[it.idx][hw], {"R5 line ", it.lbl}, out_line, m_line[it.idx][hw]);
          end else begin
            chk(out_victim == 2'(m_rr[it.idx]), {"R8 victim ", it.lbl}, out_victim, m_rr[it.idx]);
          end
          if (it.upd) begin
            if (it.wmode == 0) way = it.wway;
            else if (it.wmode == 2 && eh) way = hw;
            else way = m_rr[it.idx];
            upd_en = 1'b1; upd_way = 2'(way); upd_tag = TAG_W'(it.ntag);
            upd_state = 2'(it.nst); upd_line_we = it.we; upd_line = it.line;
            m_tag[it.idx][way] = it.ntag;
            m_st[it.idx][way]  = it.nst;
            if (it.we) begin m_line[it.idx][way] = it.line; m_lk[it.idx][way] = 1; end
            if (!eh) m_rr[it.idx] = (m_rr[it.idx] + 1) % WAYS;
          end
        end
      end
      if (!out_valid && q.size() > 0 && (adv_cnt - q[0].t0) > 2)
        chk(1'b0, "R2 missing result", adv_cnt - q[0].t0, 2);
    end
  end

  // watchdog
  initial begin
    #(100000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // stimulus
  initial begin
    int sets_pick [4];
    sets_pick = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1 no result after reset", out_valid, 0);
    @(negedge clk);

    // R1: cold miss, victim 0
    lookup(3, 8'h11, 0, 0, 0, 0, '0, "R1");
    // R4 fill, then R6 / R7 back-to-back followers
    lookup(3, 8'h11, 1, 1, 2, 1, 64'hA1A1_0000_0000_0011, "R4");
    lookup(3, 8'h11, 0, 0, 0, 0, '0, "R6");
    lookup(3, 8'h11, 0, 0, 0, 0, '0, "R7");
    // R8: rotate the victim pointer in set 3
    lookup(3, 8'h22, 1, 1, 1, 1, 64'h2222, "R8");
    lookup(3, 8'h33, 1, 1, 1, 1, 64'h3333, "R8");
    lookup(3, 8'h44, 1, 1, 1, 1, 64'h4444, "R8");
    lookup(3, 8'h55, 1, 1, 1, 1, 64'h5555, "R8");
    lookup(3, 8'h11, 0, 0, 0, 0, '0, "R8 wrapped");
    lookup(4, 8'h11, 0, 0, 0, 0, '0, "R8 other set");
    // R10: tag/state only
    lookup(3, 8'h22, 1, 2, 3, 0, 64'hDEAD, "R10");
    idle(3);
    lookup(3, 8'h22, 0, 0, 0, 0, '0, "R10 line kept");
    // R3: invalidate then miss
    lookup(3, 8'h33, 1, 2, 0, 0, '0, "R3 inval");
    lookup(3, 8'h33, 0, 0, 0, 0, '0, "R3 after inval");
    idle(3);
    // R9: stall with a pending write request at the exit
    lookup(5, 8'h66, 1, 1, 2, 1, 64'h6666, "R9");
    lookup(5, 8'h66, 0, 0, 0, 0, '0, "R9");
    lookup(5, 8'h77, 0, 0, 0, 0, '0, "R9");
    stall_cycles(3);
    lookup(5, 8'h66, 0, 0, 0, 0, '0, "R9 after stall");
    lookup(5, 8'h77, 0, 0, 0, 0, '0, "R9 after stall");
    idle(2);
    stall_cycles(2);
    lookup(5, 8'h66, 0, 0, 0, 0, '0, "R9 no leak");
    // mixed traffic
    for (int i = 0; i < 80; i++) begin
      int r, st, ix, tg;
      r  = $urandom % 10;
      ix = sets_pick[$urandom % 4];
      tg = 8'h30 + ($urandom % 5);
      st = 1 + ($urandom % 3);
      if (r < 4)      lookup(ix, tg, 0, 0, 0, 0, '0, "R6 mix");
      else if (r < 8) lookup(ix, tg, 1, 2, st, $urandom % 2, {$urandom, $urandom}, "R7 mix");
      else            lookup(ix, tg, 1, 2, 0, 0, '0, "R3 mix");
      if ((i % 17) == 16) stall_cycles(1);
    end
    idle(1);
    for (int i = 0; i < 50 && q.size() > 0; i++) idle(1);
    chk(q.size() == 0, "R2 drained", q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule